// File: doc/BRIEF.md
# PS/2 Port Register Interface

This block is the memory-mapped register front end for a single keyboard or mouse port. A processor reaches it over a simple 32-bit peripheral bus that completes every word access in one cycle. Read data comes back registered in the cycle after the access. The block keeps a control register, a clock-divisor register, a small receive queue with a holding register for the most recent byte handed to software, and a read-only identification window at the top of its 4 KB space. It drives one level-sensitive interrupt.

On the link side, a serial engine (not part of this block) delivers each received byte with a one-cycle valid strobe and takes transmit bytes through a valid/ready pair. Software reads the data register to drain received bytes. It writes the data register to send a byte to the device. Status and interrupt-identification reads report whether a byte is waiting.

Top module: `ps2_port_regs`

## Requirements
- R1: Word index (address bits 11:2) selects the register: 0 control (read/write), 1 status (read-only), 2 data (read/write), 3 clock divisor (read/write), 4 interrupt identification (read-only). Address bits 1:0 are ignored. A control write stores all 32 bits, and a control read returns them.
- R2: A read at word index 0x3F8 through 0x3FF (byte offsets 0xFE0 to 0xFFC) returns, in the low byte, the identification bytes 0x50, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order. Writes to these indices are ignored.
- R3: The irq output is high exactly when control bit 3 is set, or when control bit 4 is set and a received byte is pending. It follows the state registers, so it reflects a control write or a queue change from the next cycle on.
- R4: A status read returns 0x10 when a received byte is pending and 0x00 otherwise.
- R5: A data read with a byte pending removes the oldest queued byte, stores it in the holding register and returns it. A data read with nothing pending returns the holding register unchanged.
- R6: An interrupt-identification read returns the pending flag in bit 0, with bit 1 always one and every other bit zero.
- R7: A data write raises tx_valid in the same cycle, with tx_byte equal to write-data bits 7:0, provided tx_ready is high. With tx_ready low the byte is discarded and tx_valid stays low. tx_valid is never high outside a data write.
- R8: The clock-divisor register stores and returns all 32 written bits and has no effect on irq.
- R9: Received bytes enter a 4-entry first-in first-out queue, and "pending" means that queue is non-empty. A byte that arrives while the queue holds 4 entries is dropped, even if a data read removes one in the same cycle.
- R10: A read from any other word index returns zero. A write to status, interrupt identification, or any other unlisted index changes no state.
- R11: Reset clears control, divisor, holding register, read data and the queue, so irq is low and all registers read zero.
- R12: bus_rdata changes only in the cycle after a read access, and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rx_valid | input | 1 | Received-byte strobe from the link engine |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | Transmit byte offered |
| tx_byte | output | 8 | Transmit byte |
| tx_ready | input | 1 | Link engine can take a transmit byte |
| irq | output | 1 | Level interrupt |

## Verification
The checker checks on every cycle the following properties:
- irq responds to control writes of the two enable bits.
- The queue never exceeds its depth, and a full queue refuses arrivals.
- Only a pending data read moves the holding register.
- Read data stays put between reads.
- tx_valid never rises without tx_ready.

Only the bench scenarios can show the rest:
- the identification byte order;
- first-in first-out ordering across an overflow;
- the drop-while-popping corner;
- the fall-back to the held byte when the queue is empty;
- the discarded transmit write.

The bench exposes these by comparing every cycle against a behavioural model.

// File: rtl/ps2_regs_pkg.sv
package ps2_regs_pkg;

  localparam int unsigned WORD_IDX_W = 10;

  localparam logic [WORD_IDX_W-1:0] IDX_CTRL   = 10'd0;
  localparam logic [WORD_IDX_W-1:0] IDX_STAT   = 10'd1;
  localparam logic [WORD_IDX_W-1:0] IDX_DATA   = 10'd2;
  localparam logic [WORD_IDX_W-1:0] IDX_DIV    = 10'd3;
  localparam logic [WORD_IDX_W-1:0] IDX_IRQID  = 10'd4;
  localparam logic [WORD_IDX_W-1:0] IDX_IDBASE = 10'h3F8;

  localparam int unsigned CTRL_RXIE_BIT = 4;
  localparam int unsigned CTRL_TXIE_BIT = 3;

  function automatic logic [7:0] ident_byte(input logic [2:0] slot);
    case (slot)
      3'd0:    return 8'h50;
      3'd1:    return 8'h10;
      3'd2:    return 8'h04;
      3'd3:    return 8'h00;
      3'd4:    return 8'h0D;
      3'd5:    return 8'hF0;
      3'd6:    return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction

  function automatic logic irq_level(input logic pending, input logic [31:0] ctrl);
    return (pending & ctrl[CTRL_RXIE_BIT]) | ctrl[CTRL_TXIE_BIT];
  endfunction

  function automatic logic [31:0] status_word(input logic pending);
    return pending ? 32'h0000_0010 : 32'h0;
  endfunction

  function automatic logic [31:0] irqid_word(input logic pending);
    return {30'd0, 1'b1, pending};
  endfunction

endpackage

// File: rtl/ps2_rx_fifo.sv
module ps2_rx_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned WIDTH = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           push,
  input  logic [WIDTH-1:0]               push_data,
  input  logic                           pop,
  output logic [WIDTH-1:0]               head,
  output logic [$clog2(DEPTH+1)-1:0]     count,
  output logic                           full,
  output logic                           empty
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH+1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] rd_ptr_q, wr_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);
  assign count = cnt_q;
  assign head  = mem_q[rd_ptr_q];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          mem_q[i] <= '0;
        end else if (push && wr_ptr_q == PTR_W'(i)) begin
          mem_q[i] <= push_data;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (pop)  rd_ptr_q <= ptr_next(rd_ptr_q);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

endmodule

// File: rtl/ps2_reg_decode.sv
module ps2_reg_decode
  import ps2_regs_pkg::*;
(
  input  logic                  sel,
  input  logic                  write,
  input  logic [11:0]           addr,
  output logic [WORD_IDX_W-1:0] idx,
  output logic                  rd_any,
  output logic                  wr_ctrl,
  output logic                  wr_div,
  output logic                  wr_data,
  output logic                  rd_data
);
  assign idx     = addr[11:2];
  assign rd_any  = sel & ~write;
  assign wr_ctrl = sel & write & (idx == IDX_CTRL);
  assign wr_div  = sel & write & (idx == IDX_DIV);
  assign wr_data = sel & write & (idx == IDX_DATA);
  assign rd_data = rd_any & (idx == IDX_DATA);
endmodule

// File: rtl/ps2_port_regs.sv
module ps2_port_regs
  import ps2_regs_pkg::*;
#(
  parameter int unsigned RX_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_write,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  output logic        tx_valid,
  output logic [7:0]  tx_byte,
  input  logic        tx_ready,
  output logic        irq
);
  localparam int unsigned CNT_W = $clog2(RX_DEPTH+1);

  logic [WORD_IDX_W-1:0] acc_idx;
  logic acc_rd, wr_ctrl, wr_div, wr_data, rd_data;

  logic [31:0] ctrl_q, div_q, rdata_q, rd_mux;
  logic [7:0]  hold_q, rx_head;
  logic [CNT_W-1:0] rx_count;
  logic rx_full, rx_empty, rx_pending, rx_push, rx_pop;

  ps2_reg_decode u_dec (
    .sel     (bus_sel),
    .write   (bus_write),
    .addr    (bus_addr),
    .idx     (acc_idx),
    .rd_any  (acc_rd),
    .wr_ctrl (wr_ctrl),
    .wr_div  (wr_div),
    .wr_data (wr_data),
    .rd_data (rd_data)
  );

  assign rx_pending = ~rx_empty;
  assign rx_push    = rx_valid & ~rx_full;
  assign rx_pop     = rd_data & rx_pending;

  ps2_rx_fifo #(.DEPTH(RX_DEPTH), .WIDTH(8)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (rx_push),
    .push_data (rx_byte),
    .pop       (rx_pop),
    .head      (rx_head),
    .count     (rx_count),
    .full      (rx_full),
    .empty     (rx_empty)
  );

  always_comb begin
    rd_mux = '0;
    if (acc_idx >= IDX_IDBASE) begin
      rd_mux = {24'd0, ident_byte(acc_idx[2:0])};
    end else begin
      case (acc_idx)
        IDX_CTRL:  rd_mux = ctrl_q;
        IDX_STAT:  rd_mux = status_word(rx_pending);
        IDX_DATA:  rd_mux = {24'd0, rx_pending ? rx_head : hold_q};
        IDX_DIV:   rd_mux = div_q;
        IDX_IRQID: rd_mux = irqid_word(rx_pending);
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      div_q   <= '0;
      hold_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q  <= bus_wdata;
      if (wr_div)  div_q   <= bus_wdata;
      if (rx_pop)  hold_q  <= rx_head;
      if (acc_rd)  rdata_q <= rd_mux;
    end
  end

  assign bus_rdata = rdata_q;
  assign tx_valid  = wr_data & tx_ready;
  assign tx_byte   = bus_wdata[7:0];
  assign irq       = irq_level(rx_pending, ctrl_q);

endmodule

// File: rtl/ps2_port_regs_chk.sv
module ps2_port_regs_chk #(
  parameter int unsigned RX_DEPTH = 4,
  parameter int unsigned CNT_W    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_rd,
  input logic             wr_ctrl,
  input logic [31:0]      bus_wdata,
  input logic             irq,
  input logic             rx_valid,
  input logic             rx_push,
  input logic             rx_pop,
  input logic             rx_pending,
  input logic             rx_full,
  input logic [CNT_W-1:0] rx_count,
  input logic [7:0]       hold_q,
  input logic [31:0]      bus_rdata,
  input logic             tx_valid,
  input logic             tx_ready
);
  a_r3_txie_raises: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl && bus_wdata[3] |=> irq);
  a_r3_both_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl && bus_wdata[4:3] == 2'b00 |=> !irq);
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CNT_W'(RX_DEPTH));
  a_r9_full_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_full |-> !rx_push);
  a_r5_pop_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> rx_pending);
  a_r5_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_pop |=> $stable(hold_q));
  a_r12_rdata_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_rd |=> $stable(bus_rdata));
  a_r7_tx_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_ready);
endmodule

bind ps2_port_regs ps2_port_regs_chk #(.RX_DEPTH(RX_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_rd     (acc_rd),
  .wr_ctrl    (wr_ctrl),
  .bus_wdata  (bus_wdata),
  .irq        (irq),
  .rx_valid   (rx_valid),
  .rx_push    (rx_push),
  .rx_pop     (rx_pop),
  .rx_pending (rx_pending),
  .rx_full    (rx_full),
  .rx_count   (rx_count),
  .hold_q     (hold_q),
  .bus_rdata  (bus_rdata),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready)
);

// File: tb/ps2_port_regs_bench.sv
module ps2_port_regs_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_sel = 0, bus_write = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 0;
  logic [7:0]  rx_byte = '0;
  logic        tx_valid;
  logic [7:0]  tx_byte;
  logic        tx_ready = 1;
  logic        irq;

  int vectors = 0;
  int fails = 0;

  always #2 clk = ~clk;

  ps2_port_regs u_ps2_port_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_valid(tx_valid),
    .tx_byte(tx_byte), .tx_ready(tx_ready), .irq(irq)
  );

  byte unsigned q[$];
  logic [31:0] m_ctrl = 0, m_div = 0, m_rdata = 0;
  logic [7:0]  m_hold = 0;
  logic        m_irq = 0;
  string       m_tag = "R11";

  function automatic logic [7:0] id_expect(int k);
    byte unsigned tbl[8] = '{8'h50, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    return tbl[k];
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: advances on every rising edge from the inputs held there
  always @(posedge clk) begin
    int idx;
    bit was_full;
    if (!rst_n) begin
      q.delete();
      m_ctrl = 0; m_div = 0; m_hold = 0; m_rdata = 0; m_tag = "R11";
    end else begin
      idx = int'(bus_addr[11:2]);
      was_full = (q.size() >= 4);
      if (bus_sel && bus_write && idx == 2 && tx_ready) begin
        check("R7 tx_valid", {31'd0, tx_valid}, 32'd1);
        check("R7 tx_byte", {24'd0, tx_byte}, {24'd0, bus_wdata[7:0]});
      end else begin
        check("R7 tx_valid idle", {31'd0, tx_valid}, 32'd0);
      end
      if (bus_sel && !bus_write) begin
        if (idx >= 'h3F8) begin
          m_rdata = {24'd0, id_expect(idx - 'h3F8)}; m_tag = "R2";
        end else begin
          case (idx)
            0: begin m_rdata = m_ctrl; m_tag = "R1"; end
            1: begin m_rdata = (q.size() != 0) ? 32'h10 : 32'h0; m_tag = "R4"; end
            2: begin
              if (q.size() != 0) begin m_hold = q.pop_front(); end
              m_rdata = {24'd0, m_hold}; m_tag = "R5";
            end
            3: begin m_rdata = m_div; m_tag = "R8"; end
            4: begin m_rdata = {30'd0, 1'b1, q.size() != 0}; m_tag = "R6"; end
            default: begin m_rdata = 0; m_tag = "R10"; end
          endcase
        end
      end
      if (bus_sel && bus_write && idx == 0) m_ctrl = bus_wdata;
      if (bus_sel && bus_write && idx == 3) m_div = bus_wdata;
      if (rx_valid && !was_full) q.push_back(rx_byte);
    end
    m_irq = ((q.size() != 0) && m_ctrl[4]) || m_ctrl[3];
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check({m_tag, " R12 rdata"}, bus_rdata, m_rdata);
      check("R3 irq", {31'd0, irq}, {31'd0, m_irq});
    end
  end

  task automatic idle();
    @(negedge clk);
    bus_sel = 0; bus_write = 0; rx_valid = 0;
  endtask

  task automatic wr(int idx, logic [31:0] v);
    @(negedge clk);
    bus_sel = 1; bus_write = 1; bus_addr = 12'(idx << 2); bus_wdata = v; rx_valid = 0;
  endtask

  task automatic rd(int idx);
    @(negedge clk);
    bus_sel = 1; bus_write = 0; bus_addr = 12'(idx << 2); rx_valid = 0;
  endtask

  task automatic rx(logic [7:0] b);
    @(negedge clk);
    bus_sel = 0; rx_valid = 1; rx_byte = b;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11: reset state
    rd(0); rd(3); rd(2); rd(1); rd(4); idle();
    // R1, R8: register read-back; divisor leaves irq alone
    wr(0, 32'hA5A5_0004); wr(3, 32'hDEAD_BEEF); rd(0); rd(3); idle();
    // R2: identification window, with low address bits set on one
    for (int k = 0; k < 8; k++) rd('h3F8 + k);
    @(negedge clk); bus_sel = 1; bus_write = 0; bus_addr = 12'hFE3;
    idle();
    // R3, R4, R6, R5, R9: three bytes, status, pop in order, then fall back
    wr(0, 32'h10);
    rx(8'h11); rx(8'h22); rx(8'h33); idle();
    rd(1); rd(4); rd(2); rd(2); rd(2); rd(2); rd(1); rd(4); idle();
    // R9: overflow drops the 5th and 6th bytes
    for (int k = 0; k < 6; k++) rx(8'h40 + 8'(k));
    idle();
    for (int k = 0; k < 5; k++) rd(2);
    idle();
    // R9: arrival while full and popping is dropped
    for (int k = 0; k < 4; k++) rx(8'h60 + 8'(k));
    @(negedge clk); bus_sel = 1; bus_write = 0; bus_addr = 12'h008; rx_valid = 1; rx_byte = 8'h99;
    idle();
    for (int k = 0; k < 5; k++) rd(2);
    // R3: tx-enable bit alone drives irq; both off clears it
    wr(0, 32'h08); idle(); wr(0, 32'h00); idle();
    // R7: transmit with and without ready
    wr(2, 32'h0000_12C3); idle();
    tx_ready = 0; wr(2, 32'h0000_0077); idle(); tx_ready = 1;
    // R10: unmapped reads and writes, writes to read-only registers
    wr(1, 32'hFFFF_FFFF); wr(4, 32'hFFFF_FFFF); wr(8, 32'hFFFF_FFFF); wr('h3F9, 32'h0);
    rd(5); rd(8); rd('h3F7); rd(0); rd(3); rd(1); rd('h3F9); idle();
    // R11: reset mid-run
    rx(8'h5A); wr(0, 32'h18); idle();
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    rd(0); rd(2); rd(1); idle(); idle();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule